// File: doc/BRIEF.md
# ECC Scrubbing Refresh Sequencer

This block runs in the background of an SDRAM controller. It works through the memory one location at a time. At each step it opens a row in one bank and reads a single 128-bit word together with its 8 check bits. It then decodes the Hamming code. If the word holds a correctable flip, the block writes the repaired word and fresh check bits back to the same address. Finally it closes the bank and stays quiet for a set interval. Opening and then closing a row restores the charge in that row. The walk is paced so that every row of every bank is opened inside the retention window, so the device's own auto-refresh can be left off while the sequencer runs.

Commands leave through a single valid/op/address port and are taken only in a cycle where the main arbiter raises `grant`. Read data comes back on `rd_valid`, after any latency. The block enforces its own minimum spacing between commands. Error status appears as sticky flags, saturating counters and the address of the first uncorrectable word. If the arbiter holds off the scrubber for so long that the retention window is at risk, `urgent` asks for priority.

Top module: `scrub_refresh_seq`

## Requirements
- R1: Check bits follow a Hamming layout. Codeword positions start at 1. Check bit j sits at position 2^j. Data bits 0 upward fill the positions that are not powers of two, in increasing order, so data bit 0 is at 3 and data bit 127 is at 136. Check bit j is the XOR of the data bits whose position has bit j set. The syndrome is the received check bits XOR the recomputed ones; it is the position of a single flipped bit. When the syndrome is between 1 and 136, the read is followed by a write to the same bank, row and column. That write carries the repaired data and recomputed check bits.
- R2: A syndrome above 136 marks the word uncorrectable. No write follows the read, and the uncorrectable status is raised.
- R3: Every step issues activate, then read, then write (only when R1 applies), then precharge, all to one bank, row and column. Op codes are 0 activate, 1 read, 2 write, 3 precharge.
- R4: After each precharge the address moves on with the bank as the innermost digit, the row next and the column outermost. Every field wraps to zero.
- R5: A command counts as issued only in a cycle with `cmd_valid` and `grant` both high. While `grant` is low, an offered command and its address stay unchanged.
- R6: A read issues no earlier than T_RCD cycles after its activate.
- R7: A precharge issues no earlier than T_WR cycles after a write.
- R8: An activate issues no earlier than max(GAP_CYC, T_RP) cycles after the previous precharge.
- R9: A pass ends with the precharge at the highest bank and highest row. Within one pass, each bank/row pair is activated exactly once.
- R10: `urgent` is high while the cycles since the last pass end, saturating at WIN_CYC, are at least WIN_CYC minus URGENT_LEAD. It clears in the cycle after a pass ends.
- R11: `ce_flag` and `ue_flag` are sticky. `ce_count` and `ue_count` count corrected and uncorrectable reads and stop at their maximum value.
- R12: `ue_addr` holds {col,row,bank} of the first uncorrectable read; later ones leave it unchanged.
- R13: In reset, `cmd_valid`, `urgent`, the flags, the counts and `ue_addr` are zero, and the address is bank 0, row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Arbiter accepts the offered command this cycle |
| cmd_valid | output | 1 | A command is offered |
| cmd_op | output | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | output | BANK_W | Bank address |
| cmd_row | output | ROW_W | Row address |
| cmd_col | output | COL_W | Column address |
| wr_data | output | DATA_W | Repaired data for a write |
| wr_chk | output | CHK_W | Check bits for a write |
| rd_valid | input | 1 | Read word present this cycle |
| rd_data | input | DATA_W | Read data |
| rd_chk | input | CHK_W | Read check bits |
| urgent | output | 1 | Retention deadline at risk |
| ce_flag | output | 1 | A corrected error has occurred |
| ue_flag | output | 1 | An uncorrectable error has occurred |
| ce_count | output | CNT_W | Saturating corrected count |
| ue_count | output | CNT_W | Saturating uncorrectable count |
| ue_addr | output | COL_W+ROW_W+BANK_W | {col,row,bank} of first uncorrectable read |

## Verification
The bench flips single data bits at both ends of the codeword and a single check bit. Each of these must produce a write of the clean word. A decoder that swapped positions or left out the check-bit case would write wrong data, or no data at all. Double flips chosen to give syndromes above 136 must suppress the write-back. Those flips must leave `ue_addr` on the first bad location, and a design that repaired them or overwrote the address is caught. A long grant hold-off must raise `urgent` while the command stays frozen, and the next pass end must clear it; a late or missing clear shows up at once. More corrected errors are injected than the counter can hold, to catch a counter that wraps instead of saturating. Each command's address and cycle spacing is compared against the bank-first sweep order and the spacing minimums, so that a skipped bank or an early command is flagged.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
   typedef enum logic [1:0] {
      OP_ACT = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2,
      OP_PRE = 2'd3
   } scrub_op_e;

   typedef enum logic [2:0] {
      ST_ACT,
      ST_RD,
      ST_DATA,
      ST_WR,
      ST_PRE
   } scrub_st_e;
endpackage

// File: rtl/scrub_ecc.sv
module scrub_ecc #(
   parameter int DATA_W = 128,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0] rd_data,
   input  logic [CHK_W-1:0]  rd_chk,
   output logic [DATA_W-1:0] fix_data,
   output logic [CHK_W-1:0]  fix_chk,
   output logic              err_ce,
   output logic              err_ue
);
   localparam int CW = DATA_W + CHK_W;
   localparam logic [CHK_W-1:0] CW_V = CHK_W'(CW);

   if ((1 << CHK_W) <= CW) begin : g_bad_cfg
      $error("scrub_ecc: CHK_W too small for DATA_W");
   end

   function automatic logic [DATA_W-1:0] chk_mask(input int j);
      logic [DATA_W-1:0] m;
      int cnt;
      m = '0;
      cnt = 0;
      for (int p = 1; p <= CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (((p >> j) & 1) == 1) m[cnt] = 1'b1;
            cnt++;
         end
      end
      return m;
   endfunction

   function automatic int data_pos(input int idx);
      int cnt;
      int pos;
      cnt = 0;
      pos = 0;
      for (int p = 1; p <= CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == idx) pos = p;
            cnt++;
         end
      end
      return pos;
   endfunction

   logic [CHK_W-1:0] calc_rd;
   logic [CHK_W-1:0] syn;

   for (genvar gj = 0; gj < CHK_W; gj++) begin : g_par
      localparam logic [DATA_W-1:0] MASK = chk_mask(gj);
      assign calc_rd[gj] = ^(rd_data & MASK);
      assign fix_chk[gj] = ^(fix_data & MASK);
   end

   assign syn = rd_chk ^ calc_rd;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fix
      localparam int POS = data_pos(gi);
      assign fix_data[gi] = rd_data[gi] ^ (syn == CHK_W'(POS));
   end

   assign err_ce = (syn != '0) && (syn <= CW_V);
   assign err_ue = (syn > CW_V);
endmodule

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 10,
   parameter int COL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic              pass_last
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank <= '0;
         row  <= '0;
         col  <= '0;
      end else if (step) begin
         bank <= bank + 1'b1;
         if (&bank) begin
            row <= row + 1'b1;
            if (&row) col <= col + 1'b1;
         end
      end
   end

   assign pass_last = (&bank) & (&row);
endmodule

// File: rtl/scrub_err_log.sv
module scrub_err_log #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_ce,
   input  logic              hit_ue,
   input  logic [ADDR_W-1:0] addr,
   output logic              ce_flag,
   output logic              ue_flag,
   output logic [CNT_W-1:0]  ce_cnt,
   output logic [CNT_W-1:0]  ue_cnt,
   output logic [ADDR_W-1:0] ue_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_flag <= 1'b0;
         ue_flag <= 1'b0;
         ce_cnt  <= '0;
         ue_cnt  <= '0;
         ue_addr <= '0;
      end else begin
         if (hit_ce) begin
            ce_flag <= 1'b1;
            if (!(&ce_cnt)) ce_cnt <= ce_cnt + 1'b1;
         end
         if (hit_ue) begin
            ue_flag <= 1'b1;
            if (!(&ue_cnt)) ue_cnt <= ue_cnt + 1'b1;
            if (!ue_flag) ue_addr <= addr;
         end
      end
   end
endmodule

// File: rtl/scrub_refresh_seq.sv
module scrub_refresh_seq
   import scrub_pkg::*;
#(
   parameter int BANK_W      = 2,
   parameter int ROW_W       = 10,
   parameter int COL_W       = 8,
   parameter int DATA_W      = 128,
   parameter int CHK_W       = 8,
   parameter int CNT_W       = 16,
   parameter int T_RCD       = 3,
   parameter int T_WR        = 3,
   parameter int T_RP        = 3,
   parameter int GAP_CYC     = 1600,
   parameter int WIN_CYC     = 12_800_000,
   parameter int URGENT_LEAD = 1_000_000
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            grant,
   output logic                            cmd_valid,
   output logic [1:0]                      cmd_op,
   output logic [BANK_W-1:0]               cmd_bank,
   output logic [ROW_W-1:0]                cmd_row,
   output logic [COL_W-1:0]                cmd_col,
   output logic [DATA_W-1:0]               wr_data,
   output logic [CHK_W-1:0]                wr_chk,
   input  logic                            rd_valid,
   input  logic [DATA_W-1:0]               rd_data,
   input  logic [CHK_W-1:0]                rd_chk,
   output logic                            urgent,
   output logic                            ce_flag,
   output logic                            ue_flag,
   output logic [CNT_W-1:0]                ce_count,
   output logic [CNT_W-1:0]                ue_count,
   output logic [COL_W+ROW_W+BANK_W-1:0]   ue_addr
);
   localparam int ADDR_W   = COL_W + ROW_W + BANK_W;
   localparam int IDLE_CYC = (GAP_CYC > T_RP) ? GAP_CYC : T_RP;
   localparam int MAX_WAIT = (IDLE_CYC > T_RCD) ? ((IDLE_CYC > T_WR) ? IDLE_CYC : T_WR)
                                                : ((T_RCD > T_WR) ? T_RCD : T_WR);
   localparam int WAIT_W   = $clog2(MAX_WAIT + 1);
   localparam int TIM_W    = $clog2(WIN_CYC + 1);
   localparam longint STEPS     = longint'(1) << (BANK_W + ROW_W);
   localparam longint PASS_WORST = STEPS * longint'(IDLE_CYC + T_RCD + T_WR + 8);
   localparam logic [TIM_W-1:0] WIN_V = TIM_W'(WIN_CYC);
   localparam logic [TIM_W-1:0] URG_V = TIM_W'(WIN_CYC - URGENT_LEAD);

   if (T_RCD < 1 || T_WR < 1 || T_RP < 1 || GAP_CYC < 1) begin : g_bad_tim
      $error("scrub_refresh_seq: timing minimums must be at least 1");
   end
   if (URGENT_LEAD < 1 || URGENT_LEAD >= WIN_CYC) begin : g_bad_lead
      $error("scrub_refresh_seq: URGENT_LEAD out of range");
   end
   if (PASS_WORST > longint'(WIN_CYC - URGENT_LEAD)) begin : g_bad_win
      $error("scrub_refresh_seq: a full pass cannot fit in the retention window");
   end

   scrub_st_e         st_q;
   logic [WAIT_W-1:0] wait_q;
   logic [TIM_W-1:0]  pass_tmr_q;
   logic [DATA_W-1:0] wb_data_q;
   logic [CHK_W-1:0]  wb_chk_q;
   scrub_op_e         op_e;
   logic              issue;
   logic              step;
   logic              pass_last;
   logic [DATA_W-1:0] fix_data;
   logic [CHK_W-1:0]  fix_chk;
   logic              err_ce;
   logic              err_ue;
   logic              hit_ce;
   logic              hit_ue;

   scrub_ecc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_ecc (
      .rd_data  (rd_data),
      .rd_chk   (rd_chk),
      .fix_data (fix_data),
      .fix_chk  (fix_chk),
      .err_ce   (err_ce),
      .err_ue   (err_ue)
   );

   scrub_addr_gen #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .bank      (cmd_bank),
      .row       (cmd_row),
      .col       (cmd_col),
      .pass_last (pass_last)
   );

   scrub_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_ce  (hit_ce),
      .hit_ue  (hit_ue),
      .addr    ({cmd_col, cmd_row, cmd_bank}),
      .ce_flag (ce_flag),
      .ue_flag (ue_flag),
      .ce_cnt  (ce_count),
      .ue_cnt  (ue_count),
      .ue_addr (ue_addr)
   );

   always_comb begin
      case (st_q)
         ST_RD:   op_e = OP_RD;
         ST_WR:   op_e = OP_WR;
         ST_PRE:  op_e = OP_PRE;
         default: op_e = OP_ACT;
      endcase
   end

   assign cmd_valid = (st_q != ST_DATA) && (wait_q == '0);
   assign cmd_op    = op_e;
   assign issue     = cmd_valid && grant;
   assign step      = issue && (st_q == ST_PRE);
   assign hit_ce    = (st_q == ST_DATA) && rd_valid && err_ce;
   assign hit_ue    = (st_q == ST_DATA) && rd_valid && err_ue;
   assign wr_data   = wb_data_q;
   assign wr_chk    = wb_chk_q;
   assign urgent    = (pass_tmr_q >= URG_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_ACT;
         wait_q    <= WAIT_W'(1);
         wb_data_q <= '0;
         wb_chk_q  <= '0;
      end else begin
         if (wait_q != '0) wait_q <= wait_q - 1'b1;
         case (st_q)
            ST_ACT: if (issue) begin
               st_q   <= ST_RD;
               wait_q <= WAIT_W'(T_RCD - 1);
            end
            ST_RD: if (issue) st_q <= ST_DATA;
            ST_DATA: if (rd_valid) begin
               if (err_ce) begin
                  st_q      <= ST_WR;
                  wb_data_q <= fix_data;
                  wb_chk_q  <= fix_chk;
               end else begin
                  st_q <= ST_PRE;
               end
            end
            ST_WR: if (issue) begin
               st_q   <= ST_PRE;
               wait_q <= WAIT_W'(T_WR - 1);
            end
            ST_PRE: if (issue) begin
               st_q   <= ST_ACT;
               wait_q <= WAIT_W'(IDLE_CYC - 1);
            end
            default: st_q <= ST_ACT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pass_tmr_q <= '0;
      end else if (step && pass_last) begin
         pass_tmr_q <= '0;
      end else if (pass_tmr_q != WIN_V) begin
         pass_tmr_q <= pass_tmr_q + 1'b1;
      end
   end
endmodule

// File: rtl/scrub_refresh_seq_chk.sv
module scrub_refresh_seq_chk
   import scrub_pkg::*;
#(
   parameter int BANK_W   = 2,
   parameter int ROW_W    = 10,
   parameter int COL_W    = 8,
   parameter int CNT_W    = 16,
   parameter int T_RCD    = 3,
   parameter int T_WR     = 3,
   parameter int IDLE_CYC = 1600
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          grant,
   input logic                          cmd_valid,
   input logic [1:0]                    cmd_op,
   input logic [BANK_W-1:0]             cmd_bank,
   input logic [ROW_W-1:0]              cmd_row,
   input logic [COL_W-1:0]              cmd_col,
   input logic                          urgent,
   input logic                          ce_flag,
   input logic                          ue_flag,
   input logic [CNT_W-1:0]              ce_count,
   input logic [CNT_W-1:0]              ue_count,
   input logic [COL_W+ROW_W+BANK_W-1:0] ue_addr
);
   logic        iss;
   logic [31:0] since_act;
   logic [31:0] since_wr;
   logic [31:0] since_pre;
   logic [1:0]  last_op;

   assign iss = cmd_valid && grant;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '1;
         since_wr  <= '1;
         since_pre <= '1;
         last_op   <= OP_PRE;
      end else begin
         if (since_act != '1) since_act <= since_act + 1'b1;
         if (since_wr  != '1) since_wr  <= since_wr + 1'b1;
         if (since_pre != '1) since_pre <= since_pre + 1'b1;
         if (iss) begin
            last_op <= cmd_op;
            if (cmd_op == OP_ACT) since_act <= 32'd1;
            if (cmd_op == OP_WR)  since_wr  <= 32'd1;
            if (cmd_op == OP_PRE) since_pre <= 32'd1;
         end
      end
   end

   a_r3_rd_after_act: assert property (@(posedge clk) disable iff (!rst_n)
      iss && cmd_op == OP_RD |-> last_op == OP_ACT);
   a_r3_act_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      iss && cmd_op == OP_ACT |-> last_op == OP_PRE);
   a_r3_pre_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      iss && cmd_op == OP_PRE |-> (last_op == OP_RD || last_op == OP_WR));
   a_r5_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !grant |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                              && $stable(cmd_row) && $stable(cmd_col));
   a_r6_act_to_rd: assert property (@(posedge clk) disable iff (!rst_n)
      iss && cmd_op == OP_RD |-> since_act >= 32'(T_RCD));
   a_r7_wr_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
      iss && cmd_op == OP_PRE && last_op == OP_WR |-> since_wr >= 32'(T_WR));
   a_r8_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
      iss && cmd_op == OP_ACT |-> since_pre >= 32'(IDLE_CYC));
   a_r10_urgent_clears: assert property (@(posedge clk) disable iff (!rst_n)
      iss && cmd_op == OP_PRE && (&cmd_bank) && (&cmd_row) |=> !urgent);
   a_r11_ce_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ce_flag |=> ce_flag);
   a_r11_ue_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ue_flag |=> ue_flag);
   a_r11_ce_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ce_count != '0 |=> ce_count != '0);
   a_r11_ue_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ue_count != '0 |=> ue_count != '0);
   a_r12_first_ue_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ue_flag |=> $stable(ue_addr));
endmodule

bind scrub_refresh_seq scrub_refresh_seq_chk #(
   .BANK_W   (BANK_W),
   .ROW_W    (ROW_W),
   .COL_W    (COL_W),
   .CNT_W    (CNT_W),
   .T_RCD    (T_RCD),
   .T_WR     (T_WR),
   .IDLE_CYC ((GAP_CYC > T_RP) ? GAP_CYC : T_RP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grant     (grant),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_bank  (cmd_bank),
   .cmd_row   (cmd_row),
   .cmd_col   (cmd_col),
   .urgent    (urgent),
   .ce_flag   (ce_flag),
   .ue_flag   (ue_flag),
   .ce_count  (ce_count),
   .ue_count  (ue_count),
   .ue_addr   (ue_addr)
);

// File: tb/scrub_refresh_seq_bench.sv
`timescale 1ns/1ps
module scrub_refresh_seq_bench;
   localparam int BW = 2, RW = 3, CWD = 2, DW = 128, KW = 8, NW = 2;
   localparam int TRCD = 2, TWR = 3, TRP = 3, GAP = 6, WIN = 2000, LEAD = 200;
   localparam int IDLE = (GAP > TRP) ? GAP : TRP;
   localparam int AW = BW + RW + CWD;

   logic clk, rst_n, grant, cmd_valid, rd_valid, urgent, ce_flag, ue_flag;
   logic [1:0] cmd_op;
   logic [BW-1:0] cmd_bank;
   logic [RW-1:0] cmd_row;
   logic [CWD-1:0] cmd_col;
   logic [DW-1:0] wr_data, rd_data;
   logic [KW-1:0] wr_chk, rd_chk;
   logic [NW-1:0] ce_count, ue_count;
   logic [AW-1:0] ue_addr;

   scrub_refresh_seq #(
      .BANK_W(BW), .ROW_W(RW), .COL_W(CWD), .DATA_W(DW), .CHK_W(KW), .CNT_W(NW),
      .T_RCD(TRCD), .T_WR(TWR), .T_RP(TRP), .GAP_CYC(GAP), .WIN_CYC(WIN),
      .URGENT_LEAD(LEAD)
   ) u_scrub_refresh_seq (
      .clk(clk), .rst_n(rst_n), .grant(grant), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .wr_data(wr_data),
      .wr_chk(wr_chk), .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
      .urgent(urgent), .ce_flag(ce_flag), .ue_flag(ue_flag), .ce_count(ce_count),
      .ue_count(ue_count), .ue_addr(ue_addr)
   );

   typedef struct {
      int op; int bank; int row; int col;
      logic [DW-1:0] data; logic [KW-1:0] chk;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0, errors = 0, pre_seen = 0;
   longint cyc = 0;
   bit done = 0;
   logic [DW+KW-1:0] mem [0:127];

   initial begin
      clk = 0;
      forever #2.5 clk = ~clk;
   end
   initial forever @(posedge clk) cyc++;

   function automatic logic [KW-1:0] enc(input logic [DW-1:0] d);
      logic [KW-1:0] c = '0;
      int k = 0;
      for (int p = 1; p <= DW + KW; p++) begin
         if ((p & (p - 1)) != 0) begin
            for (int j = 0; j < KW; j++) if (((p >> j) & 1) == 1) c[j] ^= d[k];
            k++;
         end
      end
      return c;
   endfunction

   function automatic logic [DW-1:0] clean(input int s);
      logic [DW-1:0] d;
      for (int k = 0; k < 4; k++) d[k*32 +: 32] = 32'hC0DE_0000 ^ (s << 8) ^ k;
      return d;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [135:0] act,
                      input logic [135:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic push_step(input int s, input bit wb);
      exp_t e;
      e.bank = s % 4; e.row = (s / 4) % 8; e.col = (s / 32) % 4;
      e.data = clean(s); e.chk = enc(e.data);
      e.op = 0; exp_q.push_back(e);
      e.op = 1; exp_q.push_back(e);
      if (wb) begin e.op = 2; exp_q.push_back(e); end
      e.op = 3; exp_q.push_back(e);
   endtask

   // Memory model, scoreboard monitor, timing and pass checks.
   initial begin
      int rd_pend = 0, rd_idx = 0;
      longint t_act = -1000, t_wr = -1000, t_pre = -1000;
      logic [31:0] act_mask = '0;
      bit urg_chk = 0;
      rd_valid = 0; rd_data = '0; rd_chk = '0;
      forever begin
         @(negedge clk);
         rd_valid = 0;
         if (urg_chk) begin
            chk(urgent == 1'b0, "R10 urgent clear after pass end", 136'(urgent), 136'(0));
            urg_chk = 0;
         end
         if (rd_pend > 0) begin
            rd_pend--;
            if (rd_pend == 0) begin
               rd_valid = 1;
               rd_data = mem[rd_idx][DW-1:0];
               rd_chk = mem[rd_idx][DW+KW-1:DW];
            end
         end
         if (rst_n && cmd_valid && grant) begin
            exp_t e;
            int idx;
            idx = int'(cmd_col) * 32 + int'(cmd_row) * 4 + int'(cmd_bank);
            if (exp_q.size() == 0) begin
               chk(0, "R3 unexpected command", 136'(cmd_op), 136'(0));
            end else begin
               e = exp_q.pop_front();
               chk(int'(cmd_op) == e.op, "R3 op order", 136'(cmd_op), 136'(e.op));
               chk(int'(cmd_bank) == e.bank && int'(cmd_row) == e.row && int'(cmd_col) == e.col,
                   "R4 sweep address", 136'(idx), 136'(e.col * 32 + e.row * 4 + e.bank));
               if (e.op == 2)
                  chk(wr_data == e.data && wr_chk == e.chk, "R1 write-back word",
                      {wr_chk, wr_data}, {e.chk, e.data});
            end
            case (cmd_op)
               2'd0: begin
                  chk(cyc - t_pre >= IDLE, "R8 pre to act", 136'(cyc - t_pre), 136'(IDLE));
                  chk(act_mask[idx % 32] == 1'b0, "R9 row activated once per pass",
                      136'(act_mask), 136'(0));
                  act_mask[idx % 32] = 1'b1;
                  t_act = cyc;
               end
               2'd1: begin
                  chk(cyc - t_act >= TRCD, "R6 act to rd", 136'(cyc - t_act), 136'(TRCD));
                  rd_pend = 2;
                  rd_idx = idx;
               end
               2'd2: begin
                  mem[idx] = {wr_chk, wr_data};
                  t_wr = cyc;
               end
               default: begin
                  if (t_wr > t_act)
                     chk(cyc - t_wr >= TWR, "R7 wr to pre", 136'(cyc - t_wr), 136'(TWR));
                  t_pre = cyc;
                  pre_seen++;
                  if (cmd_bank == 2'd3 && cmd_row == 3'd7) begin
                     chk(act_mask == '1, "R9 all rows of all banks per pass",
                         136'(act_mask), 136'(32'hFFFF_FFFF));
                     act_mask = '0;
                     urg_chk = 1;
                  end
               end
            endcase
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_pre(input int n);
      while (pre_seen < n) @(negedge clk);
   endtask

   initial begin
      int held;
      rst_n = 0;
      grant = 0;
      for (int s = 0; s < 128; s++) mem[s] = {enc(clean(s)), clean(s)};
      mem[1][5]        ^= 1'b1;
      mem[2][DW+3]     ^= 1'b1;
      mem[12][127]     ^= 1'b1;
      mem[40][0]       ^= 1'b1;
      mem[70][DW+0]    ^= 1'b1;
      mem[5][120]      ^= 1'b1; mem[5][11]  ^= 1'b1;
      mem[9][121]      ^= 1'b1; mem[9][12]  ^= 1'b1;
      mem[75][120]     ^= 1'b1; mem[75][11] ^= 1'b1;
      for (int s = 0; s < 100; s++)
         push_step(s, (s == 1 || s == 2 || s == 12 || s == 40 || s == 70));
      repeat (4) @(negedge clk);
      chk(cmd_valid == 0 && urgent == 0 && ce_flag == 0 && ue_flag == 0,
          "R13 reset control outputs", 136'({cmd_valid, urgent, ce_flag, ue_flag}), 136'(0));
      chk(ce_count == 0 && ue_count == 0 && ue_addr == 0, "R13 reset status",
          136'({ce_count, ue_count, ue_addr}), 136'(0));
      chk(cmd_bank == 0 && cmd_row == 0 && cmd_col == 0, "R13 reset address",
          136'({cmd_col, cmd_row, cmd_bank}), 136'(0));
      @(posedge clk); #1 rst_n = 1; grant = 1;

      wait_pre(4); @(negedge clk);
      chk(ce_count == 2 && ce_flag == 1, "R1 two corrected reads", 136'(ce_count), 136'(2));
      chk(ue_flag == 0, "R2 no uncorrectable yet", 136'(ue_flag), 136'(0));
      wait_pre(16); @(negedge clk);
      chk(ue_count == 2 && ue_flag == 1, "R2 two uncorrectable reads", 136'(ue_count), 136'(2));
      chk(ue_addr == 7'd5, "R12 first uncorrectable address", 136'(ue_addr), 136'(5));
      chk(ce_count == 3, "R11 corrected count at three", 136'(ce_count), 136'(3));
      wait_pre(31); @(negedge clk);
      chk(urgent == 0, "R10 no urgent with full grant", 136'(urgent), 136'(0));

      wait_pre(36);
      @(posedge clk); #1 grant = 0;
      held = pre_seen;
      repeat (2100) @(posedge clk);
      @(negedge clk);
      chk(urgent == 1, "R10 urgent after long hold-off", 136'(urgent), 136'(1));
      chk(cmd_valid == 1 && pre_seen == held, "R5 command waits for grant",
          136'(pre_seen), 136'(held));
      @(posedge clk); #1 grant = 1;

      wait_pre(64);
      for (int k = 0; pre_seen < 96; k++) begin
         @(posedge clk); #1 grant = (k % 3 != 2);
      end
      grant = 1;
      @(negedge clk);
      chk(ce_count == 3 && ce_flag == 1, "R11 corrected count saturates", 136'(ce_count), 136'(3));
      chk(ue_count == 3 && ue_flag == 1, "R2 third uncorrectable counted", 136'(ue_count), 136'(3));
      chk(ue_addr == 7'd5, "R12 first address kept", 136'(ue_addr), 136'(5));
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule